// File: doc/BRIEF.md
# Retired-Instruction Trace Checker

This block sits beside a processor core and watches the stream of records the core emits as it retires instructions. Every record is offered with a valid strobe. It carries a program-order index, the address of the retired instruction and the address that follows it, an interrupt flag, a skip flag, and one memory access. The access is made of an address, a byte read mask, a byte write mask, and a 64-bit read and write data word.

The checker tests each accepted record against a fixed set of sequencing and field rules. The first rule that fails raises a sticky error flag and latches a 3-bit code that names the rule. Both stay until a synchronous reset. The checker never pushes back on the stream: `rec_ready` is held high, so a record is accepted in every cycle where `rec_valid` is high. A producer may send records back to back or with idle gaps, and nothing is taken in a cycle where `rec_valid` is low. The rules cover stream order and field consistency only. Instruction meaning, register values and architectural state are not tracked.

Error codes: 1 index, 2 chaining, 3 current-address alignment, 4 next-address alignment, 5 memory alignment, 6 skipped record with an access, 7 data outside the masked lanes.

Top module: `retire_trace_chk`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears `err_flag` to 0 and `err_code` to 0. It also sets the expected index back to 0 and forgets any previous record.
- R2: `rec_ready` is always 1. While `rec_valid` is low, no field has any effect on `err_flag`, `err_code` or the tracking state.
- R3: The first record after reset must carry index 0. Each later record must carry the previous record's index plus one. Otherwise the error code is 1.
- R4: A record that is not the first must have `rec_cia` equal to the previous record's `rec_nia`, unless the previous record had `rec_intr` set. Otherwise the error code is 2.
- R5: `rec_cia[1:0]` must be 0, otherwise the error code is 3. `rec_nia[1:0]` must be 0, otherwise the error code is 4.
- R6: With parameter MEM_ALIGNED=1 (the default), a record whose read mask or write mask is nonzero must have `mem_addr[2:0]` equal to 0. Otherwise the error code is 5. A record with both masks zero is not checked for memory alignment.
- R7: A record with `rec_skip` set must have both masks zero, otherwise the error code is 6.
- R8: Mask bit k covers byte lane k, which is data bits 8k+7..8k. Every read-data byte whose read-mask bit is 0 must be zero, and every write-data byte whose write-mask bit is 0 must be zero. Otherwise the error code is 7.
- R9: `err_flag` and `err_code` change one clock edge after the offending record is accepted. When one record breaks several rules, the smallest code is latched. Once set, the flag and the code hold, whatever later records carry, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_valid | input | 1 | Record offered this cycle |
| rec_ready | output | 1 | Always 1; the checker never stalls |
| rec_order | input | 64 | Program-order index |
| rec_cia | input | 64 | Address of the retired instruction |
| rec_nia | input | 64 | Address of the following instruction |
| rec_intr | input | 1 | Interrupt taken during this record |
| rec_skip | input | 1 | Record retired without being executed |
| mem_addr | input | 64 | Memory access address |
| mem_rmask | input | 8 | Read byte-lane mask |
| mem_wmask | input | 8 | Write byte-lane mask |
| mem_rdata | input | 64 | Read data |
| mem_wdata | input | 64 | Write data |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 3 | Code of the first violated rule |

## Verification
The main rules are driven with several kinds of stimulus:
- A legal 20-record stream, mixing interrupts, skips, jumps and full-lane reads, shows that legal traffic raises nothing.
- Sweeps of the low address bits of the current, next and memory addresses separate aligned values from every misaligned value, and show that an access with empty masks is exempt.
- A sweep of one nonzero data byte across all eight lanes, with the mask bit for that lane cleared, set, or as the only cleared bit, tells lane-hygiene faults apart from legal data.
- Index gaps, repeats and nonzero starting indexes separate index faults from chaining faults. Jumps after an interrupt record are set against jumps without one.
- Records that break two rules at once, and records sent after an error, confirm the priority order and the sticky hold.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    ERR_NONE  = 3'd0,
    ERR_ORDER = 3'd1,
    ERR_CHAIN = 3'd2,
    ERR_CIA   = 3'd3,
    ERR_NIA   = 3'd4,
    ERR_MEMA  = 3'd5,
    ERR_SKIP  = 3'd6,
    ERR_LANE  = 3'd7
  } err_code_e;

  localparam int unsigned N_RULES = 7;
  localparam int unsigned CODE_W  = 3;
endpackage

// File: rtl/rtc_seq.sv
// Tracks index and control-flow state carried from one accepted record to the next.
module rtc_seq #(
  parameter int unsigned IDX_W  = 64,
  parameter int unsigned ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [IDX_W-1:0]  order,
  input  logic [ADDR_W-1:0] cia,
  input  logic [ADDR_W-1:0] nia,
  input  logic              intr,
  output logic              viol_order,
  output logic              viol_chain
);
  logic [IDX_W-1:0]  exp_order_q;
  logic [ADDR_W-1:0] prev_nia_q;
  logic              prev_intr_q;
  logic              have_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      exp_order_q <= '0;
      prev_nia_q  <= '0;
      prev_intr_q <= 1'b0;
      have_prev_q <= 1'b0;
    end else if (valid) begin
      exp_order_q <= order + IDX_W'(1);
      prev_nia_q  <= nia;
      prev_intr_q <= intr;
      have_prev_q <= 1'b1;
    end
  end

  assign viol_order = valid && (order != exp_order_q);
  assign viol_chain = valid && have_prev_q && !prev_intr_q && (cia != prev_nia_q);

  // R3: the first record after reset must start at index 0
  p_first_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (valid && !have_prev_q && order != '0) |-> viol_order);

  // R4: the very first record is never flagged for chaining
  p_first_nochain_r4: assert property (@(posedge clk) disable iff (rst)
    (!have_prev_q) |-> !viol_chain);
endmodule

// File: rtl/rtc_field.sv
// Per-record field checks: address alignment, skip consistency, lane hygiene.
module rtc_field #(
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned LANES       = 8,
  parameter int unsigned INST_BYTES  = 4,
  parameter bit          MEM_ALIGNED = 1'b1
) (
  input  logic [ADDR_W-1:0]  cia,
  input  logic [ADDR_W-1:0]  nia,
  input  logic               skip,
  input  logic [ADDR_W-1:0]  maddr,
  input  logic [LANES-1:0]   rmask,
  input  logic [LANES-1:0]   wmask,
  input  logic [LANES*8-1:0] rdata,
  input  logic [LANES*8-1:0] wdata,
  output logic               viol_cia,
  output logic               viol_nia,
  output logic               viol_mem,
  output logic               viol_skip,
  output logic               viol_lane
);
  localparam int unsigned INST_LSB = $clog2(INST_BYTES);
  localparam int unsigned MEM_LSB  = $clog2(LANES);
  localparam logic [ADDR_W-1:0] INST_MASK = ADDR_W'((1 << INST_LSB) - 1);
  localparam logic [ADDR_W-1:0] MEM_MASK  = ADDR_W'((1 << MEM_LSB) - 1);

  logic             any_access;
  logic [LANES-1:0] lane_bad;

  assign any_access = (|rmask) || (|wmask);
  assign viol_cia   = (cia & INST_MASK) != '0;
  assign viol_nia   = (nia & INST_MASK) != '0;
  assign viol_skip  = skip && any_access;

  generate
    if (MEM_ALIGNED) begin : g_mem_chk
      assign viol_mem = any_access && ((maddr & MEM_MASK) != '0);
    end else begin : g_mem_free
      assign viol_mem = 1'b0;
    end
  endgenerate

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_bad[k] = (!rmask[k] && (rdata[8*k +: 8] != 8'h00)) ||
                         (!wmask[k] && (wdata[8*k +: 8] != 8'h00));
  end

  assign viol_lane = |lane_bad;
endmodule

// File: rtl/rtc_err_latch.sv
// Priority-selects the lowest violated rule and holds it until reset.
module rtc_err_latch
  import rtc_pkg::*;
#(
  parameter int unsigned N = N_RULES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N-1:0]      viol,
  output logic              err_flag,
  output logic [CODE_W-1:0] err_code
);
  logic [CODE_W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (viol[i]) pick = CODE_W'(i + 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag <= 1'b0;
      err_code <= '0;
    end else if (!err_flag && (|viol)) begin
      err_flag <= 1'b1;
      err_code <= pick;
    end
  end

  // R9: the flag is sticky
  p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag);
  // R9: the latched code holds
  p_code_hold_r9: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> $stable(err_code));
  // R9: any violation while clear is captured on the next edge
  p_catch_r9: assert property (@(posedge clk) disable iff (rst)
    (!err_flag && (|viol)) |=> (err_flag && err_code != '0));
endmodule

// File: rtl/retire_trace_chk.sv
module retire_trace_chk
  import rtc_pkg::*;
#(
  parameter int unsigned IDX_W       = 64,
  parameter int unsigned ADDR_W      = 64,
  parameter int unsigned LANES       = 8,
  parameter int unsigned INST_BYTES  = 4,
  parameter bit          MEM_ALIGNED = 1'b1,
  localparam int unsigned DATA_W     = LANES * 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_valid,
  output logic              rec_ready,
  input  logic [IDX_W-1:0]  rec_order,
  input  logic [ADDR_W-1:0] rec_cia,
  input  logic [ADDR_W-1:0] rec_nia,
  input  logic              rec_intr,
  input  logic              rec_skip,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [LANES-1:0]  mem_rmask,
  input  logic [LANES-1:0]  mem_wmask,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [DATA_W-1:0] mem_wdata,
  output logic              err_flag,
  output logic [CODE_W-1:0] err_code
);
  logic v_order, v_chain, v_cia, v_nia, v_mem, v_skip, v_lane;
  logic [N_RULES-1:0] raw_viol;
  logic [N_RULES-1:0] gated_viol;

  assign rec_ready = 1'b1;

  rtc_seq #(.IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .valid      (rec_valid),
    .order      (rec_order),
    .cia        (rec_cia),
    .nia        (rec_nia),
    .intr       (rec_intr),
    .viol_order (v_order),
    .viol_chain (v_chain)
  );

  rtc_field #(
    .ADDR_W(ADDR_W), .LANES(LANES), .INST_BYTES(INST_BYTES), .MEM_ALIGNED(MEM_ALIGNED)
  ) u_field (
    .cia       (rec_cia),
    .nia       (rec_nia),
    .skip      (rec_skip),
    .maddr     (mem_addr),
    .rmask     (mem_rmask),
    .wmask     (mem_wmask),
    .rdata     (mem_rdata),
    .wdata     (mem_wdata),
    .viol_cia  (v_cia),
    .viol_nia  (v_nia),
    .viol_mem  (v_mem),
    .viol_skip (v_skip),
    .viol_lane (v_lane)
  );

  // bit i corresponds to error code i+1
  assign raw_viol   = {v_lane, v_skip, v_mem, v_nia, v_cia, v_chain, v_order};
  assign gated_viol = raw_viol & {N_RULES{rec_valid}};

  rtc_err_latch #(.N(N_RULES)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .viol     (gated_viol),
    .err_flag (err_flag),
    .err_code (err_code)
  );

  // R1: reset clears the error state
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!err_flag && err_code == '0));
  // R2: an idle cycle cannot raise the flag
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (!rec_valid && !err_flag) |=> !err_flag);
  // R2: the checker never back-pressures
  p_ready_r2: assert property (@(posedge clk) disable iff (rst)
    rec_valid |-> rec_ready);
  // R5: a misaligned current address on an accepted record is caught
  p_cia_caught_r5: assert property (@(posedge clk) disable iff (rst)
    (rec_valid && rec_cia[0]) |=> err_flag);
endmodule

// File: tb/retire_trace_chk_bench.sv
module retire_trace_chk_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rec_valid = 1'b0;
  logic        rec_ready;
  logic [63:0] rec_order = '0, rec_cia = '0, rec_nia = '0;
  logic        rec_intr = 1'b0, rec_skip = 1'b0;
  logic [63:0] mem_addr = '0;
  logic [7:0]  mem_rmask = '0, mem_wmask = '0;
  logic [63:0] mem_rdata = '0, mem_wdata = '0;
  logic        err_flag;
  logic [2:0]  err_code;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  retire_trace_chk u_retire_trace_chk (
    .clk(clk), .rst(rst), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_order(rec_order), .rec_cia(rec_cia), .rec_nia(rec_nia),
    .rec_intr(rec_intr), .rec_skip(rec_skip), .mem_addr(mem_addr),
    .mem_rmask(mem_rmask), .mem_wmask(mem_wmask),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata),
    .err_flag(err_flag), .err_code(err_code)
  );

  task automatic do_reset();
    @(negedge clk) rst = 1'b1; rec_valid = 1'b0;
    @(negedge clk) rst = 1'b0;
  endtask

  // Drives one record for one cycle; returns at the next negedge, after capture.
  task automatic send(input logic [63:0] o, input logic [63:0] c, input logic [63:0] n,
                      input logic it, input logic sk, input logic [63:0] ma,
                      input logic [7:0] rm, input logic [7:0] wm,
                      input logic [63:0] rd, input logic [63:0] wd);
    @(negedge clk);
    rec_valid = 1'b1; rec_order = o; rec_cia = c; rec_nia = n;
    rec_intr = it; rec_skip = sk; mem_addr = ma; mem_rmask = rm;
    mem_wmask = wm; mem_rdata = rd; mem_wdata = wd;
    @(negedge clk);
    rec_valid = 1'b0;
  endtask

  task automatic expect_code(input string req, input logic [2:0] exp_c);
    logic [3:0] act, exp_v;
    act   = {err_flag, err_code};
    exp_v = {exp_c != 3'd0, exp_c};
    total++;
    if (act !== exp_v) begin
      bad++;
      $display("FAIL %s: flag/code actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=expired expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pn;
    logic        pi;
    do_reset();
    expect_code("R1 reset state", 3'd0);

    // R2: garbage with valid low, then ready check
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rec_order = 64'd99; rec_cia = 64'h3; rec_nia = 64'h7; rec_skip = 1'b1;
      mem_rmask = 8'h0F; mem_addr = 64'h5; mem_rdata = '1;
    end
    @(negedge clk);
    expect_code("R2 idle ignored", 3'd0);
    total++;
    if (rec_ready !== 1'b1) begin
      bad++; $display("FAIL R2 ready: actual=%b expected=1", rec_ready);
    end
    // R2: state untouched by idle garbage: index 0 still accepted first
    send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
    expect_code("R2 R3 index after idle", 3'd0);

    // R3 R4: legal stream of 20 records
    do_reset();
    pn = 64'h2000; pi = 1'b0;
    for (int i = 0; i < 20; i++) begin
      logic [63:0] c, n, rd;
      logic [7:0]  rm;
      c  = pi ? (64'h7000 + 64'(i) * 64'h10) : pn;
      n  = ((i % 5) == 3) ? c + 64'h40 : c + 64'h4;
      rm = ((i % 3) == 0) ? 8'hFF : 8'h00;
      rd = ((i % 3) == 0) ? {8{8'(i)}} : 64'h0;
      send(64'(i), c, n, (i % 7) == 4, (i % 6) == 5, 64'h8000 + 64'(i) * 8,
           rm, 8'h00, rd, 64'h0);
      expect_code("R3 R4 legal stream", 3'd0);
      pn = n; pi = ((i % 7) == 4);
    end

    // R3: nonzero first index
    for (int k = 1; k < 4; k++) begin
      do_reset();
      send(64'(k), 64'h100, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      expect_code("R3 first index nonzero", 3'd1);
    end
    // R3: gap and repeat
    for (int k = 0; k < 2; k++) begin
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      send((k == 0) ? 64'd2 : 64'd0, 64'h104, 64'h108, 1'b0, 1'b0,
           64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      expect_code("R3 index gap/repeat", 3'd1);
    end

    // R4: chain break without and with interrupt
    for (int k = 0; k < 2; k++) begin
      do_reset();
      send(64'd0, 64'h100, 64'h104, k == 1, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      send(64'd1, 64'h900, 64'h904, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      expect_code("R4 chain after intr/no intr", (k == 1) ? 3'd0 : 3'd2);
    end

    // R5: low bit sweeps of current and next address
    for (int b = 0; b < 4; b++) begin
      do_reset();
      send(64'd0, 64'h100 + 64'(b), 64'h200, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      expect_code("R5 cia alignment", (b != 0) ? 3'd3 : 3'd0);
      do_reset();
      send(64'd0, 64'h100, 64'h200 + 64'(b), 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
      expect_code("R5 nia alignment", (b != 0) ? 3'd4 : 3'd0);
    end

    // R6: memory address sweep, with read access, write access, and none
    for (int a = 0; a < 8; a++) begin
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h40 + 64'(a), 8'h01, 8'h0, 64'h0, 64'h0);
      expect_code("R6 mem align read", (a != 0) ? 3'd5 : 3'd0);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h40 + 64'(a), 8'h0, 8'h80, 64'h0, 64'h0);
      expect_code("R6 mem align write", (a != 0) ? 3'd5 : 3'd0);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h40 + 64'(a), 8'h0, 8'h0, 64'h0, 64'h0);
      expect_code("R6 no access exempt", 3'd0);
    end

    // R7 and R8: lane sweep
    for (int k = 0; k < 8; k++) begin
      logic [7:0]  lm;
      logic [63:0] dv;
      lm = 8'(1 << k);
      dv = 64'hA5 << (8 * k);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b1, 64'h0, lm, 8'h0, 64'h0, 64'h0);
      expect_code("R7 skip with read mask", 3'd6);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b1, 64'h0, 8'h0, lm, 64'h0, 64'h0);
      expect_code("R7 skip with write mask", 3'd6);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, dv, 64'h0);
      expect_code("R8 read byte unmasked", 3'd7);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h0, lm, 8'h0, dv, 64'h0);
      expect_code("R8 read byte masked", 3'd0);
      do_reset();
      send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, ~lm, 64'h0, dv);
      expect_code("R8 write byte in cleared lane", 3'd7);
    end
    do_reset();
    send(64'd0, 64'h100, 64'h104, 1'b0, 1'b1, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
    expect_code("R7 skip without access", 3'd0);

    // R9: priority and stickiness
    do_reset();
    send(64'd1, 64'h102, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
    expect_code("R9 lowest code wins", 3'd1);
    do_reset();
    send(64'd0, 64'h100, 64'h106, 1'b0, 1'b1, 64'h0, 8'h0, 8'h0, 64'hFF, 64'h0);
    expect_code("R9 nia beats lane", 3'd4);
    do_reset();
    send(64'd0, 64'h100, 64'h104, 1'b0, 1'b0, 64'h4, 8'h01, 8'h0, 64'h0, 64'h0);
    expect_code("R9 first error", 3'd5);
    send(64'd7, 64'h3, 64'h104, 1'b0, 1'b0, 64'h0, 8'h0, 8'h0, 64'h0, 64'h0);
    expect_code("R9 sticky hold", 3'd5);
    do_reset();
    expect_code("R1 reset clears latched error", 3'd0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule